// File: doc/BRIEF.md
# Envelope Step Rate Prescaler

This block produces the clock-enable strobe that paces an envelope counter. A binary divider would work, but this block uses a 15-bit shift register with XOR feedback. It compares the register against one of sixteen fixed match states, picked by a 4-bit rate code. When the register reaches the selected state, it reloads to all ones and the block raises a one-cycle step tick. On every other enabled cycle the register shifts once. The number of cycles between ticks is therefore set by how far each match state lies from the all-ones state along the shift sequence.

A small controller with two named states sequences the block. ST_RUN is the shifting phase. ST_STEP is the cycle in which the tick is high and the register again holds all ones. The transitions are:
- RUN_TO_STEP on an enabled match.
- STEP_TO_RUN on an enabled cycle with no match.
- RUN_HOLD on an enabled cycle with no match.
- FREEZE whenever the enable input is low, which leaves the controller state unchanged.

The datapath and the controller share one enable, so a low enable stops both. A downstream envelope counter steps by one for each tick.

Top module: `envpre_rate_prescaler`

## Requirements
- R1: While reset is high, the shift register is loaded with 0x7FFF and the tick is low. After reset releases, the first clock edge is the first shift.
- R2: On an enabled cycle with no match, the register shifts left by one. The new bit 0 is bit 14 XOR bit 13 of the old state, and the result is kept to 15 bits.
- R3: On an enabled cycle where the register equals the selected match state, the register reloads to 0x7FFF. The tick is high in the following cycle.
- R4: Each tick is high for exactly one enabled cycle.
- R5: Rate code r (0 to 15) selects a match state (hex) as follows. 0:7F00, 1:0006, 2:003C, 3:0330, 4:20C0, 5:6755, 6:3800, 7:500E, 8:1212, 9:0222, 10:1848, 11:59B8, 12:3840, 13:77E2, 14:7625, 15:0A93.
- R6: At a fixed rate, ticks repeat every N cycles, where N is one more than the number of shifts from 0x7FFF to the match state. The first tick after reset appears N edges after release. For rate 0, N is 9.
- R7: A new rate code is used from the next compare and does not reload the register. If the new match state has already been passed, the register runs through the rest of its sequence before it matches.
- R8: While the enable is low, both the register and the tick keep their values, including a tick that is currently high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low freezes the block |
| rate | input | 4 | Rate code selecting the match state |
| tick | output | 1 | Envelope step strobe, registered |

## Verification
The bench uses the package defaults: a 15-bit state, taps at bits 14 and 13, and a 4-bit rate code. With these values, all sixteen rate codes can be swept within the cycle budget. Every code is timed from reset release to its first tick. The twelve shortest codes are also timed tick to tick. The bench takes its expected periods from its own model of the shift sequence and the match states. The same model predicts when a mid-count rate change will tick, both for a match state still ahead of the register and for one already passed, which forces nearly the full 32767-state cycle.

// File: rtl/envpre_pkg.sv
package envpre_pkg;

    localparam int STATE_W = 15;
    localparam int RATE_W  = 4;
    localparam int TAP_HI  = 14;
    localparam int TAP_LO  = 13;
    localparam int N_RATES = 1 << RATE_W;

    typedef logic [STATE_W-1:0] state_t;
    typedef logic [RATE_W-1:0]  rate_t;

    localparam state_t SEED = {STATE_W{1'b1}};

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_STEP = 1'b1
    } phase_e;

    // Match state for each rate code
    function automatic state_t match_state(input rate_t r);
        state_t v;
        unique case (r)
            4'h0: v = 15'h7F00;
            4'h1: v = 15'h0006;
            4'h2: v = 15'h003C;
            4'h3: v = 15'h0330;
            4'h4: v = 15'h20C0;
            4'h5: v = 15'h6755;
            4'h6: v = 15'h3800;
            4'h7: v = 15'h500E;
            4'h8: v = 15'h1212;
            4'h9: v = 15'h0222;
            4'hA: v = 15'h1848;
            4'hB: v = 15'h59B8;
            4'hC: v = 15'h3840;
            4'hD: v = 15'h77E2;
            4'hE: v = 15'h7625;
            default: v = 15'h0A93;
        endcase
        return v;
    endfunction

    function automatic state_t shift_once(input state_t s);
        return {s[STATE_W-2:0], s[TAP_HI] ^ s[TAP_LO]};
    endfunction

endpackage

// File: rtl/envpre_lfsr.sv
module envpre_lfsr
    import envpre_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  logic   adv,
    output state_t state
);

    state_t state_q;
    state_t state_d;

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = SEED;
        end else if (adv) begin
            state_d = shift_once(state_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/envpre_match.sv
module envpre_match
    import envpre_pkg::*;
(
    input  rate_t  rate,
    input  state_t state,
    output logic   hit
);

    state_t target;
    logic [STATE_W-1:0] diff;

    always_comb begin
        target = match_state(rate);
    end

    genvar gi;
    generate
        for (gi = 0; gi < STATE_W; gi++) begin : g_bit
            assign diff[gi] = state[gi] ^ target[gi];
        end
    endgenerate

    assign hit = ~|diff;

endmodule

// File: rtl/envpre_ctrl.sv
module envpre_ctrl
    import envpre_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic hit,
    output logic load,
    output logic adv,
    output logic tick
);

    phase_e cur_q;
    phase_e nxt;

    // Next-state selection
    always_comb begin
        nxt = cur_q;
        if (en) begin
            unique case (cur_q)
                ST_RUN:  nxt = hit ? ST_STEP : ST_RUN;
                ST_STEP: nxt = hit ? ST_STEP : ST_RUN;
                default: nxt = ST_RUN;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= ST_RUN;
        end else begin
            cur_q <= nxt;
        end
    end

    // Outputs
    always_comb begin
        load = en & hit;
        adv  = en & ~hit;
        tick = (cur_q == ST_STEP);
    end

endmodule

// File: rtl/envpre_rate_prescaler.sv
module envpre_rate_prescaler
    import envpre_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [3:0] rate,
    output logic       tick
);

    state_t lfsr_state;
    logic   hit;
    logic   load;
    logic   adv;

    envpre_lfsr u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .adv   (adv),
        .state (lfsr_state)
    );

    envpre_match u_match (
        .rate  (rate),
        .state (lfsr_state),
        .hit   (hit)
    );

    envpre_ctrl u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .hit  (hit),
        .load (load),
        .adv  (adv),
        .tick (tick)
    );

endmodule

// File: rtl/envpre_chk.sv
module envpre_chk
    import envpre_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic [3:0] rate,
    input logic       tick,
    input state_t     state
);

    logic at_match;
    assign at_match = (state == match_state(rate));

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (state == SEED) && !tick);

    assert_shift_step_R2: assert property (@(posedge clk) disable iff (rst)
        (en && !at_match) |=> state == {$past(state[STATE_W-2:0]), $past(state[TAP_HI] ^ state[TAP_LO])});

    assert_reload_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (en && at_match) |=> (state == SEED) && tick);

    assert_tick_single_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && en) |=> !tick);

    assert_tick_cause_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(tick) |-> $past(en && at_match));

    assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(state) && $stable(tick));

endmodule

bind envpre_rate_prescaler envpre_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .rate  (rate),
    .tick  (tick),
    .state (lfsr_state)
);

// File: tb/sim_envpre_rate_prescaler.sv
module sim_envpre_rate_prescaler;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b1;
    logic [3:0] rate = 4'h0;
    logic       tick;

    int n_tests = 0;
    int n_fail  = 0;
    longint cycles = 0;

    envpre_rate_prescaler u0 (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .rate (rate),
        .tick (tick)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 195000) begin
            n_fail = n_fail + 1;
            n_tests = n_tests + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Match states from R5
    function automatic logic [14:0] ref_match(input int r);
        logic [14:0] t[16] = '{15'h7F00, 15'h0006, 15'h003C, 15'h0330,
                               15'h20C0, 15'h6755, 15'h3800, 15'h500E,
                               15'h1212, 15'h0222, 15'h1848, 15'h59B8,
                               15'h3840, 15'h77E2, 15'h7625, 15'h0A93};
        return t[r];
    endfunction

    function automatic logic [14:0] ref_next(input logic [14:0] s);
        return {s[13:0], s[14] ^ s[13]};
    endfunction

    function automatic int ref_dist(input logic [14:0] s0, input logic [14:0] tgt);
        logic [14:0] s = s0;
        for (int i = 0; i < 32768; i++) begin
            if (s == tgt) return i;
            s = ref_next(s);
        end
        return -1;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts edges until tick is seen high (sampled at negedge)
    task automatic wait_tick(input int limit, output int edges);
        edges = 0;
        for (int i = 0; i < limit; i++) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (tick) return;
        end
        edges = -1;
    endtask

    task automatic do_reset(input logic [3:0] r);
        @(negedge clk);
        rst = 1'b1;
        en = 1'b1;
        rate = r;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        int e;
        int expn;
        logic [14:0] s;

        do_reset(4'h0);
        check("R1 tick low after reset", tick, 0);

        // R6/R5/R2: first tick for every rate code
        for (int r = 0; r < 16; r++) begin
            expn = ref_dist(15'h7FFF, ref_match(r)) + 1;
            do_reset(4'(r));
            wait_tick(40000, e);
            check($sformatf("R6 first tick rate %0d", r), e, expn);
            if (r < 12) begin
                @(posedge clk);
                @(negedge clk);
                check($sformatf("R4 tick width rate %0d", r), tick, 0);
                wait_tick(40000, e);
                check($sformatf("R3 period rate %0d", r), e, expn - 1);
            end
        end

        // R6: rate 0 is nine cycles
        do_reset(4'h0);
        wait_tick(100, e);
        check("R6 rate0 nine", e, 9);

        // R8: freeze mid-count
        do_reset(4'h0);
        repeat (3) @(negedge clk);
        en = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R8 no tick while frozen", tick, 0);
        end
        en = 1'b1;
        wait_tick(100, e);
        check("R8 delayed tick", e + 3, 9);

        // R8: freeze while tick high
        en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R8 tick held", tick, 1);
        end
        en = 1'b1;
        @(negedge clk);
        check("R4 tick drops on resume", tick, 0);
        wait_tick(100, e);
        check("R3 period after freeze", e + 1, 9);

        // R7: switch to a match state still ahead
        do_reset(4'h0);
        repeat (3) @(negedge clk);
        s = 15'h7FFF;
        for (int i = 0; i < 3; i++) s = ref_next(s);
        rate = 4'h1;
        expn = ref_dist(s, ref_match(1)) + 1;
        wait_tick(40000, e);
        check("R7 ahead switch", e, expn);

        // R7: switch to a match state already passed
        do_reset(4'h1);
        repeat (10) @(negedge clk);
        s = 15'h7FFF;
        for (int i = 0; i < 10; i++) s = ref_next(s);
        rate = 4'h0;
        expn = ref_dist(s, ref_match(0)) + 1;
        wait_tick(40000, e);
        check("R7 passed switch", e, expn);
        check("R7 long wrap", (expn > 30000) ? 1 : 0, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule